// File: doc/BRIEF.md
# Two-Wire Byte-Addressed Memory Slave

This block is a slave on a two-wire serial bus. Behind it sits a 2048-byte memory built from registers. The bus lines reach the block already synchronised to the system clock. The block pulls the data line low through an open-drain enable and never drives it high. Three strapped select pins give the device its bus identity, so up to eight of these blocks can share one bus.

A transfer opens with a START condition, followed by a command byte. The command byte holds a fixed leading one, three select bits, three upper address bits and a direction bit. After a write command the master sends the low address byte and then any number of data bytes. After a read command the slave returns bytes from its current address. It keeps returning bytes for as long as the master acknowledges them. A single 11-bit address counter serves both directions. The counter steps by one for every byte transferred and wraps around at the top of the memory.

Top module: `i2c_eep_slave`

## Requirements
- R1: The slave acknowledges a command byte only when bit 7 is 1, bit 6 equals pin csPins[2], bit 5 equals the inverse of csPins[1] and bit 4 equals csPins[0]. Any other command byte is not acknowledged, and the slave leaves SDA released for all bytes up to the next START.
- R2: Bit 0 of the command byte selects the direction. A 0 makes the transfer a write; a 1 makes it a read.
- R3: In a write command, bits 3..1 become address bits 10..8. In a read command, bits 3..1 are ignored and the address is left unchanged.
- R4: After an acknowledged write command, the next byte is acknowledged and becomes address bits 7..0.
- R5: Each later byte of a write transfer is acknowledged and stored at the current address, and the address then steps by one.
- R6: A read transfer returns the byte at the current address, most significant bit first, and the address steps by one for each byte sent.
- R7: A read burst continues while the master acknowledges each byte. A not-acknowledge ends the burst.
- R8: The address counter wraps from 2047 to 0.
- R9: The slave changes its SDA drive only while SCL is low. It holds SDA low through the ninth clock of every byte it receives, and it releases SDA during the ninth clock of every byte it sends.
- R10: A STOP releases SDA and returns the slave to idle. A START, including a repeated START, restarts command decoding.
- R11: After reset the slave is idle and does not drive SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Synchronised serial clock line |
| sdaIn | input | 1 | Synchronised serial data line (wired-AND bus value) |
| csPins | input | 3 | Strapped device-select pins |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The checks assume the bus inputs are already free of metastability. They also assume each SCL level lasts at least two system clocks, so that every SCL edge is seen before the data line moves again. They further assume the master never issues a START or STOP while the slave is holding SDA low. The bench drives the bus from tasks that respect these rules. Each SCL phase is held for several clocks, and SDA only changes with SCL low, except for deliberate START and STOP conditions. Repeated STARTs are issued only after an acknowledge slot, once the slave has released the line.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_CMD_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } eep_state_t;

  // Strobes from control to datapath, at most one active per cycle
  // except rxShift which only occurs in receive states.
  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic addrHiLoad;
    logic addrLoLoad;
    logic memWrite;
  } eep_strobe_t;

endpackage

// File: rtl/i2c_eep_datapath.sv
module i2c_eep_datapath
  import i2c_eep_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  eep_strobe_t       st,
  input  logic              sdaBit,
  output logic [DATA_W-1:0] rxByte,
  output logic              txMsb,
  output logic [ADDR_W-1:0] addrCur
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - DATA_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] rxReg;
  logic [DATA_W-1:0] txReg;
  logic [ADDR_W-1:0] addrReg;

  // Receive shifter, MSB arrives first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxReg <= '0;
    end else if (st.rxShift) begin
      rxReg <= {rxReg[DATA_W-2:0], sdaBit};
    end
  end

  // Transmit shifter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txReg <= '1;
    end else if (st.txLoad) begin
      txReg <= memArr[addrReg];
    end else if (st.txShift) begin
      txReg <= {txReg[DATA_W-2:0], 1'b1};
    end
  end

  // Address counter: loads from command and address bytes, steps per byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrReg <= '0;
    end else if (st.addrHiLoad) begin
      addrReg[ADDR_W-1:DATA_W] <= rxReg[HI_W:1];
    end else if (st.addrLoLoad) begin
      addrReg[DATA_W-1:0] <= rxReg;
    end else if (st.memWrite || st.txLoad) begin
      addrReg <= addrReg + 1'b1;
    end
  end

  // Storage array, no reset
  always_ff @(posedge clk) begin
    if (st.memWrite) begin
      memArr[addrReg] <= rxReg;
    end
  end

  assign rxByte  = rxReg;
  assign txMsb   = txReg[DATA_W-1];
  assign addrCur = addrReg;

endmodule

// File: rtl/i2c_eep_ctrl.sv
module i2c_eep_ctrl
  import i2c_eep_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        csPins,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txMsb,
  output eep_strobe_t       st,
  output logic              sdaDriveLow
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  eep_state_t       state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;
  logic             mAck, mAckNxt;
  logic             sclQ, sdaQ;
  logic             sclRise, sclFall, startCond, stopCond;
  logic             cmdMatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign sclRise   = sclIn & ~sclQ;
  assign sclFall   = ~sclIn & sclQ;
  assign startCond = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopCond  = sclIn & sclQ & ~sdaQ & sdaIn;

  assign cmdMatch = rxByte[7] & (rxByte[6] == csPins[2]) &
                    (rxByte[5] == ~csPins[1]) & (rxByte[4] == csPins[0]);

  always_comb begin
    stateNxt  = state;
    bitCntNxt = bitCnt;
    mAckNxt   = mAck;
    st        = '0;
    if (startCond) begin
      stateNxt  = ST_CMD;
      bitCntNxt = '0;
    end else if (stopCond) begin
      stateNxt  = ST_IDLE;
    end else begin
      unique case (state)
        ST_CMD, ST_ADDR, ST_WDATA: begin
          if (sclRise && bitCnt != LAST_BIT) begin
            st.rxShift = 1'b1;
            bitCntNxt  = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            bitCntNxt = '0;
            if (state == ST_CMD)       stateNxt = cmdMatch ? ST_CMD_ACK : ST_IDLE;
            else if (state == ST_ADDR) stateNxt = ST_ADDR_ACK;
            else                       stateNxt = ST_WACK;
          end
        end
        ST_CMD_ACK: begin
          if (sclFall) begin
            if (rxByte[0]) begin
              stateNxt  = ST_RDATA;
              st.txLoad = 1'b1;
            end else begin
              stateNxt      = ST_ADDR;
              st.addrHiLoad = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            stateNxt      = ST_WDATA;
            st.addrLoLoad = 1'b1;
          end
        end
        ST_WACK: begin
          if (sclFall) begin
            stateNxt    = ST_WDATA;
            st.memWrite = 1'b1;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            bitCntNxt = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              stateNxt  = ST_RACK;
              bitCntNxt = '0;
            end else begin
              st.txShift = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            mAckNxt = ~sdaIn;
          end else if (sclFall) begin
            if (mAck) begin
              stateNxt  = ST_RDATA;
              st.txLoad = 1'b1;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      mAck   <= 1'b0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
      mAck   <= mAckNxt;
    end
  end

  assign sdaDriveLow = (state == ST_CMD_ACK) || (state == ST_ADDR_ACK) ||
                       (state == ST_WACK) || ((state == ST_RDATA) && !txMsb);

endmodule

// File: rtl/i2c_eep_slave.sv
module i2c_eep_slave
  import i2c_eep_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] csPins,
  output logic       sdaDriveLow
);

  eep_strobe_t       strobes;
  logic [DATA_W-1:0] rxByte;
  logic              txMsb;
  logic [ADDR_W-1:0] addrCur;

  i2c_eep_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
    .csPins(csPins), .rxByte(rxByte), .txMsb(txMsb),
    .st(strobes), .sdaDriveLow(sdaDriveLow)
  );

  i2c_eep_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .st(strobes), .sdaBit(sdaIn),
    .rxByte(rxByte), .txMsb(txMsb), .addrCur(addrCur)
  );

endmodule

// File: rtl/i2c_eep_chk.sv
module i2c_eep_chk
  import i2c_eep_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclIn,
  input logic              sdaIn,
  input logic              sdaDriveLow,
  input logic [ADDR_W-1:0] addrCur,
  input eep_strobe_t       strobes
);

  // R9
  sda_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdaDriveLow) |-> !sclIn);

  // R9
  sda_fall_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdaDriveLow) |-> !sclIn);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclIn && $past(sclIn) && sdaIn && !$past(sdaIn)) |=> !sdaDriveLow);

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclIn && $past(sclIn) && !sdaIn && $past(sdaIn)) |=> !sdaDriveLow);

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.memWrite || strobes.txLoad) |=> addrCur == $past(addrCur) + 1'b1);

  // R2
  one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.memWrite, strobes.txLoad, strobes.addrHiLoad, strobes.addrLoLoad}));

endmodule

bind i2c_eep_slave i2c_eep_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn),
  .sdaDriveLow(sdaDriveLow), .addrCur(addrCur), .strobes(strobes)
);

// File: tb/i2c_eep_slave_tb_top.sv
module i2c_eep_slave_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sdaM = 1'b1;
  logic [2:0] csPins = 3'b101;
  logic       sdaDriveLow;
  logic       busSda;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  assign busSda = sdaM & ~sdaDriveLow;

  always #10 clk = ~clk;

  i2c_eep_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sclIn(scl), .sdaIn(busSda),
    .csPins(csPins), .sdaDriveLow(sdaDriveLow)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkCmd(input logic [2:0] cs, input logic [2:0] hi, input logic rd);
    return {1'b1, cs[2], ~cs[1], cs[0], hi, rd};
  endfunction

  task automatic busStart();
    sdaM = 1'b1; waitClk(4);
    scl = 1'b1;  waitClk(4);
    sdaM = 1'b0; waitClk(4);
    scl = 1'b0;  waitClk(4);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(4);
    scl = 1'b1;  waitClk(4);
    sdaM = 1'b1; waitClk(4);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitClk(4);
      scl = 1'b1;  waitClk(4);
      scl = 1'b0;  waitClk(2);
    end
    sdaM = 1'b1; waitClk(4);
    scl = 1'b1;  waitClk(2);
    ack = ~busSda;
    waitClk(2);
    scl = 1'b0;  waitClk(4);
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b, output logic relAck);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitClk(4);
      scl = 1'b1;  waitClk(2);
      b[i] = busSda;
      waitClk(2);
      scl = 1'b0;  waitClk(2);
    end
    sdaM = giveAck ? 1'b0 : 1'b1; waitClk(4);
    scl = 1'b1;  waitClk(2);
    relAck = busSda;
    waitClk(2);
    scl = 1'b0;  waitClk(2);
    sdaM = 1'b1; waitClk(2);
  endtask

  task automatic setAddr(input logic [10:0] a);
    logic ack;
    busStart();
    sendByte(mkCmd(csPins, a[10:8], 1'b0), ack);
    check({7'd0, ack}, 8'd1, "R1 R2 write cmd ack");
    sendByte(a[7:0], ack);
    check({7'd0, ack}, 8'd1, "R4 low addr ack");
  endtask

  task automatic testReset();
    check({7'd0, sdaDriveLow}, 8'd0, "R11 released after reset");
    check({7'd0, busSda}, 8'd1, "R11 bus high");
  endtask

  task automatic testWriteBurst();
    logic ack;
    setAddr(11'h123);
    foreach (wrData[i]) begin
      sendByte(wrData[i], ack);
      check({7'd0, ack}, 8'd1, "R5 data ack");
    end
    busStop();
    check({7'd0, busSda}, 8'd1, "R10 released after stop");
  endtask

  logic [7:0] wrData [4] = '{8'h11, 8'h22, 8'h33, 8'h44};

  task automatic testReadBurst();
    logic ack;
    logic rel;
    logic [7:0] b;
    setAddr(11'h123);
    busStart(); // repeated START, R10
    sendByte({mkCmd(csPins, 3'b000, 1'b1)} | 8'h0C, ack); // R3: bits 3..1 = 110 ignored
    check({7'd0, ack}, 8'd1, "R10 R2 read cmd after repeated start");
    readByte(1'b1, b, rel);
    check(b, 8'h11, "R6 R3 first read byte");
    readByte(1'b1, b, rel);
    check(b, 8'h22, "R7 second read byte");
    readByte(1'b0, b, rel);
    check(b, 8'h33, "R7 third read byte");
    check({7'd0, rel}, 8'd1, "R9 released in ninth clock of read");
    busStop();
    busStart();
    sendByte(mkCmd(csPins, 3'b111, 1'b1), ack);
    readByte(1'b0, b, rel);
    check(b, 8'h44, "R6 current address continues");
    busStop();
  endtask

  task automatic testWrap();
    logic ack;
    logic rel;
    logic [7:0] b;
    setAddr(11'h7FF);
    sendByte(8'hAA, ack);
    sendByte(8'hBB, ack);
    busStop();
    setAddr(11'h7FF);
    busStart();
    sendByte(mkCmd(csPins, 3'b000, 1'b1), ack);
    readByte(1'b1, b, rel);
    check(b, 8'hAA, "R8 byte at top address");
    readByte(1'b0, b, rel);
    check(b, 8'hBB, "R8 byte after wrap");
    busStop();
  endtask

  task automatic testMismatch();
    logic ack;
    logic rel;
    logic [7:0] b;
    busStart();
    sendByte(mkCmd(csPins, 3'b001, 1'b0) ^ 8'h20, ack); // c1 wrong
    check({7'd0, ack}, 8'd0, "R1 c1 mismatch no ack");
    sendByte(8'h23, ack);
    check({7'd0, ack}, 8'd0, "R1 idle after mismatch");
    sendByte(8'hEE, ack);
    check({7'd0, ack}, 8'd0, "R1 data ignored");
    busStart();
    sendByte(mkCmd(csPins, 3'b001, 1'b0) & 8'h7F, ack); // bit 7 zero
    check({7'd0, ack}, 8'd0, "R1 bit7 zero no ack");
    busStop();
    setAddr(11'h123);
    busStart();
    sendByte(mkCmd(csPins, 3'b000, 1'b1), ack);
    readByte(1'b0, b, rel);
    check(b, 8'h11, "R1 memory untouched by mismatched transfer");
    busStop();
  endtask

  task automatic testOtherSelect();
    logic ack;
    logic rel;
    logic [7:0] b;
    csPins = 3'b010;
    waitClk(4);
    setAddr(11'h050);
    sendByte(8'h5C, ack);
    check({7'd0, ack}, 8'd1, "R5 write with other pins");
    busStop();
    setAddr(11'h050);
    busStart();
    sendByte(mkCmd(csPins, 3'b000, 1'b1), ack);
    readByte(1'b0, b, rel);
    check(b, 8'h5C, "R6 read with other pins");
    busStop();
  endtask

  initial begin
    waitClk(5);
    rst_n = 1'b1;
    waitClk(5);
    testReset();
    testWriteBurst();
    testReadBurst();
    testWrap();
    testMismatch();
    testOtherSelect();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule